// File: doc/BRIEF.md
# Timestamp-Ordered Pixel Hit Readout

A digital readout for a rectangular pixel matrix, built around a shared timestamp counter. Whenever the counter advances, every pixel can see the new value. A pixel that receives a hit pulse stores the value that is current at that moment and holds it until it is read out. The readout then works through one timestamp at a time. Each stored timestamp is compared with the timestamp selected for readout, and a column takes part only if one of its pixels matches. Columns with no match cost no cycles. Inside the chosen column, the lowest matching row wins.

There are two modes. In streaming mode, the readout walks forward through every timestamp value once the counter has moved past it. In trigger mode, only the timestamp given in an accepted trigger is read. Each served timestamp produces a series of hit words on a valid/ready output and then a one-cycle completion pulse. The output follows the usual back-pressure rules. While `word_valid` is high and `word_ready` is low, the word must stay unchanged. A word counts as delivered only on a clock edge where both are high. The trigger input is a valid/ready handshake as well.

Top module: `tsr_readout`

## Requirements
- R1: On a clock edge where `hit_i[c*ROWS+r]` is high, pixel (column c, row r) stores the current `ts_now`, but only if it holds no unread hit. If it already holds one, it keeps its first timestamp.
- R2: With `trig_mode` low, every timestamp value the counter has moved past is served in ascending order, wrapping modulo 2^TSW. Each served value ends with a `ts_done` pulse and `done_ts` equal to that value.
- R3: With `trig_mode` high, `trig_ready` is high only while the readout is idle. One accepted trigger serves only `trig_ts`. Hits stored with other timestamps stay in the matrix.
- R4: While a timestamp is served, only pixels that stored that timestamp are output. The order is ascending column, then ascending row within a column. Columns with no match are skipped, and one word is delivered per clock while `word_ready` is high, with no idle gap.
- R5: A hit word carries the pixel column on `word_col`, the row on `word_row` and the stored timestamp on `word_ts`.
- R6: `ts_done` is high for exactly one cycle. If the timestamp had hits, this is the cycle after its last word is accepted. If it had none, this is the first serving cycle. No word is valid in the cycle after `ts_done`.
- R7: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and the word stays unchanged.
- R8: A pixel whose word has been accepted holds no hit. Serving the same timestamp again outputs nothing.
- R9: `ts_step` advances `ts_now` by one, modulo 2^TSW. On the same edge, any unread pixel whose stored timestamp equals the new counter value is discarded.
- R10: After reset, `ts_now` is 0, no pixel holds a hit, and `word_valid`, `ts_done` and `trig_ready`-in-streaming-mode are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | COLS*ROWS | Hit pulses; bit c*ROWS+r is column c, row r |
| ts_step | input | 1 | Advance the timestamp counter |
| ts_now | output | TSW | Current timestamp counter value |
| trig_mode | input | 1 | 1 = trigger mode, 0 = streaming mode |
| trig_valid | input | 1 | Trigger request |
| trig_ts | input | TSW | Timestamp to read on trigger |
| trig_ready | output | 1 | Trigger accepted when high with trig_valid |
| word_valid | output | 1 | Hit word available |
| word_ready | input | 1 | Consumer accepts the hit word |
| word_col | output | log2(COLS) | Column of the hit |
| word_row | output | log2(ROWS) | Row of the hit |
| word_ts | output | TSW | Timestamp of the hit |
| ts_done | output | 1 | Served timestamp is complete |
| done_ts | output | TSW | Timestamp that was completed |

## Verification
The assertions assume that, while a timestamp is being served, no new hit and no wrap flush can create or remove a match for it. This means a trigger names a timestamp the counter has already left, and the counter does not lap a timestamp that is still being read. They also assume `trig_mode` changes only while the block is idle. The stimulus respects all three. It changes mode only after a `ts_done`. It triggers only past timestamps. It steps the counter only while no scan is in progress.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_SCAN = 1'b1
  } rd_state_t;
endpackage

// File: rtl/tsr_pixel_array.sv
module tsr_pixel_array #(
  parameter int COLS = 8,
  parameter int ROWS = 16,
  parameter int TSW  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [COLS*ROWS-1:0]      hit_i,
  input  logic [TSW-1:0]            ts_now,
  input  logic                      flush_en,
  input  logic [TSW-1:0]            flush_ts,
  input  logic [TSW-1:0]            sel_ts,
  input  logic                      clr_en,
  input  logic [$clog2(COLS*ROWS)-1:0] clr_idx,
  output logic [COLS*ROWS-1:0]      match_o
);
  localparam int NPIX = COLS * ROWS;
  localparam int IDXW = $clog2(NPIX);

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic           held;
    logic [TSW-1:0] stamp;
    logic           drop;

    // a read or a wrap flush empties the cell; a fresh hit may refill it
    assign drop = (clr_en && (clr_idx == IDXW'(p))) ||
                  (flush_en && held && (stamp == flush_ts));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held  <= 1'b0;
        stamp <= '0;
      end else if (hit_i[p] && (!held || drop)) begin
        held  <= 1'b1;
        stamp <= ts_now;
      end else if (drop) begin
        held  <= 1'b0;
      end
    end

    assign match_o[p] = held && (stamp == sel_ts);
  end
endmodule

// File: rtl/tsr_col_scan.sv
module tsr_col_scan #(
  parameter int COLS = 8,
  parameter int ROWS = 16
) (
  input  logic [COLS*ROWS-1:0]       match_i,
  output logic                       any_o,
  output logic [$clog2(COLS)-1:0]    col_o,
  output logic [$clog2(ROWS)-1:0]    row_o
);
  localparam int COLW = $clog2(COLS);
  localparam int ROWW = $clog2(ROWS);

  logic [COLS-1:0] col_or;
  logic [ROWS-1:0] col_bits;

  // per-column OR flag
  for (genvar c = 0; c < COLS; c++) begin : g_or
    assign col_or[c] = |match_i[c*ROWS +: ROWS];
  end

  // lowest flagged column wins
  always_comb begin
    col_o = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (col_or[c]) col_o = COLW'(c);
    end
  end

  assign col_bits = match_i[col_o*ROWS +: ROWS];

  // lowest matching row in the active column wins
  always_comb begin
    row_o = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (col_bits[r]) row_o = ROWW'(r);
    end
  end

  assign any_o = |col_or;
endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
#(
  parameter int TSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_mode,
  input  logic           trig_valid,
  input  logic [TSW-1:0] trig_ts,
  output logic           trig_ready,
  input  logic [TSW-1:0] ts_now,
  input  logic           any_match,
  input  logic           word_ready,
  output logic           word_valid,
  output logic           clr_en,
  output logic           ts_done,
  output logic [TSW-1:0] sel_ts
);
  rd_state_t      st;
  logic [TSW-1:0] push_ts;
  logic           push_go;

  always_comb begin
    trig_ready = (st == RD_IDLE) && trig_mode;
    push_go    = (st == RD_IDLE) && !trig_mode && (push_ts != ts_now);
    word_valid = (st == RD_SCAN) && any_match;
    ts_done    = (st == RD_SCAN) && !any_match;
    clr_en     = word_valid && word_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RD_IDLE;
      sel_ts  <= '0;
      push_ts <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (trig_valid && trig_ready) begin
            sel_ts <= trig_ts;
            st     <= RD_SCAN;
          end else if (push_go) begin
            sel_ts <= push_ts;
            st     <= RD_SCAN;
          end
        end
        default: begin
          if (ts_done) begin
            st <= RD_IDLE;
            if (!trig_mode) push_ts <= push_ts + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tsr_readout.sv
module tsr_readout #(
  parameter int COLS = 8,
  parameter int ROWS = 16,
  parameter int TSW  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COLS*ROWS-1:0]     hit_i,
  input  logic                     ts_step,
  output logic [TSW-1:0]           ts_now,
  input  logic                     trig_mode,
  input  logic                     trig_valid,
  input  logic [TSW-1:0]           trig_ts,
  output logic                     trig_ready,
  output logic                     word_valid,
  input  logic                     word_ready,
  output logic [$clog2(COLS)-1:0]  word_col,
  output logic [$clog2(ROWS)-1:0]  word_row,
  output logic [TSW-1:0]           word_ts,
  output logic                     ts_done,
  output logic [TSW-1:0]           done_ts
);
  localparam int NPIX = COLS * ROWS;
  localparam int IDXW = $clog2(NPIX);

  logic [NPIX-1:0] match;
  logic            any_match;
  logic            clr_en;
  logic [TSW-1:0]  sel_ts;
  logic [TSW-1:0]  ts_next;

  assign ts_next = ts_now + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)       ts_now <= '0;
    else if (ts_step) ts_now <= ts_next;
  end

  tsr_pixel_array #(.COLS(COLS), .ROWS(ROWS), .TSW(TSW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_i),
    .ts_now   (ts_now),
    .flush_en (ts_step),
    .flush_ts (ts_next),
    .sel_ts   (sel_ts),
    .clr_en   (clr_en),
    .clr_idx  (IDXW'({word_col, word_row})),
    .match_o  (match)
  );

  tsr_col_scan #(.COLS(COLS), .ROWS(ROWS)) u_scan (
    .match_i (match),
    .any_o   (any_match),
    .col_o   (word_col),
    .row_o   (word_row)
  );

  tsr_ctrl #(.TSW(TSW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_mode  (trig_mode),
    .trig_valid (trig_valid),
    .trig_ts    (trig_ts),
    .trig_ready (trig_ready),
    .ts_now     (ts_now),
    .any_match  (any_match),
    .word_ready (word_ready),
    .word_valid (word_valid),
    .clr_en     (clr_en),
    .ts_done    (ts_done),
    .sel_ts     (sel_ts)
  );

  assign word_ts = sel_ts;
  assign done_ts = sel_ts;
endmodule

// File: rtl/tsr_readout_chk.sv
module tsr_readout_chk #(
  parameter int COLW = 3,
  parameter int ROWW = 4,
  parameter int TSW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_mode,
  input logic            trig_valid,
  input logic            trig_ready,
  input logic            word_valid,
  input logic            word_ready,
  input logic [COLW-1:0] word_col,
  input logic [ROWW-1:0] word_row,
  input logic [TSW-1:0]  word_ts,
  input logic            ts_done,
  input logic [TSW-1:0]  ts_now
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_col) &&
                                     $stable(word_row) && $stable(word_ts)));

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (!word_valid || (word_ts != $past(word_ts)) ||
      ({word_col, word_row} > $past({word_col, word_row}))));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ts_done |=> !word_valid);

  assert_trig_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=> !trig_ready);

  assert_push_past_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_mode && word_valid) |-> (word_ts != ts_now));
endmodule

bind tsr_readout tsr_readout_chk #(
  .COLW($clog2(COLS)), .ROWW($clog2(ROWS)), .TSW(TSW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_mode  (trig_mode),
  .trig_valid (trig_valid),
  .trig_ready (trig_ready),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .word_col   (word_col),
  .word_row   (word_row),
  .word_ts    (word_ts),
  .ts_done    (ts_done),
  .ts_now     (ts_now)
);

// File: tb/sim_tsr_readout.sv
`timescale 1ns/1ps
module sim_tsr_readout;
  localparam int COLS = 8;
  localparam int ROWS = 16;
  localparam int TSW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [COLS*ROWS-1:0] hit_i = '0;
  logic ts_step = 1'b0;
  logic [TSW-1:0] ts_now;
  logic trig_mode = 1'b0;
  logic trig_valid = 1'b0;
  logic [TSW-1:0] trig_ts = '0;
  logic trig_ready;
  logic word_valid;
  logic word_ready = 1'b1;
  logic [2:0] word_col;
  logic [3:0] word_row;
  logic [TSW-1:0] word_ts;
  logic ts_done;
  logic [TSW-1:0] done_ts;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tsr_readout #(.COLS(COLS), .ROWS(ROWS), .TSW(TSW)) u0 (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_step(ts_step), .ts_now(ts_now),
    .trig_mode(trig_mode), .trig_valid(trig_valid), .trig_ts(trig_ts),
    .trig_ready(trig_ready), .word_valid(word_valid), .word_ready(word_ready),
    .word_col(word_col), .word_row(word_row), .word_ts(word_ts),
    .ts_done(ts_done), .done_ts(done_ts)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_hits(input int n, input int pc[4], input int pr[4]);
    @(negedge clk);
    for (int i = 0; i < n; i++) hit_i[pc[i]*ROWS + pr[i]] = 1'b1;
    @(negedge clk);
    hit_i = '0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ts_step = 1'b1;
      @(negedge clk);
      ts_step = 1'b0;
    end
  endtask

  task automatic trigger(input int t);
    @(negedge clk);
    chk(trig_ready == 1'b1, "R3 trig_ready idle", int'(trig_ready), 1);
    trig_valid = 1'b1;
    trig_ts = TSW'(t);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  // samples at the current negedge first, then advances
  task automatic collect(input int n, input int ec[4], input int er[4],
                         input int ets, input string tag);
    int got = 0;
    bit fin = 1'b0;
    word_ready = 1'b1;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      if (word_valid) begin
        chk(got < n, {tag, " R4 extra word"}, got, n);
        if (got < n) begin
          chk(int'(word_col) == ec[got], {tag, " R5 col"}, int'(word_col), ec[got]);
          chk(int'(word_row) == er[got], {tag, " R5 row"}, int'(word_row), er[got]);
          chk(int'(word_ts) == ets, {tag, " R5 ts"}, int'(word_ts), ets);
        end
        got++;
      end else if (ts_done) begin
        chk(int'(done_ts) == ets, {tag, " R6 done_ts"}, int'(done_ts), ets);
        chk(got == n, {tag, " R6 word count"}, got, n);
        fin = 1'b1;
      end else if (got > 0) begin
        chk(1'b0, {tag, " R4 gap"}, got, n);
      end
      if (!fin) @(negedge clk);
    end
    if (!fin) chk(1'b0, {tag, " R6 no done"}, 0, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ts_now == 0, "R10 ts_now", int'(ts_now), 0);
    chk(word_valid == 0, "R10 word_valid", int'(word_valid), 0);
    chk(ts_done == 0, "R10 ts_done", int'(ts_done), 0);
    chk(trig_ready == 0, "R10 trig_ready", int'(trig_ready), 0);
  endtask

  // R2 R4 R5: streaming order, skipped columns
  task automatic t_push_basic;
    pulse_hits(3, '{2, 0, 0, 0}, '{5, 3, 1, 0});
    steps(1);
    chk(ts_now == 1, "R9 step", int'(ts_now), 1);
    collect(3, '{0, 0, 2, 0}, '{1, 3, 5, 0}, 0, "push0");
  endtask

  task automatic t_push_empty;
    steps(1);
    collect(0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 1, "R2 push empty");
  endtask

  task automatic t_backpressure;
    pulse_hits(2, '{3, 1, 0, 0}, '{7, 0, 0, 0});
    @(negedge clk);
    word_ready = 1'b0;
    steps(1);
    repeat (4) begin
      @(negedge clk);
      chk(word_valid == 1, "R7 valid held", int'(word_valid), 1);
      chk(word_col == 1 && word_row == 0, "R7 word stable", int'({word_col, word_row}), 16);
    end
    collect(2, '{1, 3, 0, 0}, '{0, 7, 0, 0}, 2, "R7 drain");
  endtask

  // R1 R3: first stamp kept, only the triggered value is read
  task automatic t_trig_double;
    @(negedge clk);
    trig_mode = 1'b1;
    pulse_hits(1, '{4, 0, 0, 0}, '{2, 0, 0, 0});          // stamp 3
    steps(1);
    pulse_hits(2, '{4, 5, 0, 0}, '{2, 9, 0, 0});          // stamp 4, (4,2) kept at 3
    steps(1);
    trigger(4);
    collect(1, '{5, 0, 0, 0}, '{9, 0, 0, 0}, 4, "R1 R3 trig4");
    trigger(3);
    collect(1, '{4, 0, 0, 0}, '{2, 0, 0, 0}, 3, "R1 R3 trig3");
  endtask

  task automatic t_clear;
    trigger(3);
    collect(0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 3, "R8 reread");
  endtask

  task automatic t_flush;
    pulse_hits(1, '{6, 0, 0, 0}, '{6, 0, 0, 0});          // stamp 5
    steps(33);
    chk(ts_now == 6, "R9 wrap", int'(ts_now), 6);
    trigger(5);
    collect(0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 5, "R9 flushed");
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_push_basic();
    t_push_empty();
    t_backpressure();
    t_trig_double();
    t_clear();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule